// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block turns a write to the interrupt command register into delivery requests for a small, fixed set of cores. A sender first writes the high half of the command, which holds the destination. It then writes the low half, and that write performs the send. The low half carries the vector, the delivery mode and the destination shorthand. The sender's own core index travels with the write on `cmd_src`, so that the self-relative shorthands can be resolved.

For each core the block drives two kinds of request:

- **Fixed interrupt.** A single-cycle valid pulse with an 8-bit vector.
- **NMI.** A single-cycle pulse on `nmi_fire`, which tells the core to enter its NMI handler. The core takes every NMI on vector 2, so the command's vector plays no part.

Each core owns an NMI slot that tracks one NMI in service plus one pending. A second NMI that arrives while the core is busy is therefore not lost. A third one is merged into the pending NMI.

Physical destinations are matched against the core index. In compatible mode only the destination's low 8 bits are compared. In extended mode all 32 bits are compared. The all-ones destination of the active width reaches every core.

Top module: `ipi_dispatch`

## Requirements
- R1: After synchronous reset, `fix_vld` and `nmi_fire` are all zero and no core has an NMI in service or pending.
- R2: A cycle with `cmd_hi_we` latches `cmd_wdata` as the destination and sends nothing. A cycle with `cmd_lo_we` sends using the destination latched by an earlier high write. The resulting `fix_vld` or `nmi_fire` pulse is high for exactly the one cycle after the low write.
- R3: With shorthand 00, a core is selected when its index equals the destination. In compatible mode (`ext_mode`=0) only destination bits [7:0] are compared and bits [31:8] are ignored. In extended mode all 32 bits are compared.
- R4: The destination 0x000000FF in compatible mode selects every core, and so does 0xFFFFFFFF in extended mode. In extended mode, 0x000000FF selects no core.
- R5: Shorthand bits [19:18] of the low word decode as follows, and the destination is ignored whenever the shorthand is non-zero:
  - 00: use the destination.
  - 01: the sender only (`cmd_src`).
  - 10: all cores including the sender.
  - 11: all cores except the sender.
- R6: Delivery mode bits [10:8] decode as follows:
  - 000 is fixed. It pulses `fix_vld` of each selected core and presents bits [7:0] on that core's `fix_vec`.
  - 100 is NMI.
  - Any other code delivers nothing.
- R7: An NMI command ignores its vector field: it raises no `fix_vld` and leaves every `fix_vec` unchanged.
- R8: An NMI reaching a core with no NMI in service pulses that core's `nmi_fire` in the next cycle. The core then stays in service until it pulses `nmi_done`.
- R9: An NMI reaching a core that is in service becomes pending, with no pulse. On the following `nmi_done`, the pending NMI fires in the next cycle.
- R10: An NMI that arrives while one is in service and one is pending is merged. After the pending NMI has been served, the next `nmi_done` returns the core to idle with no further pulse.
- R11: When `nmi_done` and a new NMI reach a core with a pending NMI in the same cycle, the pending NMI fires and the new NMI becomes pending.
- R12: A fixed interrupt sent after an NMI by the same sender reaches the core in a later cycle than that NMI's pulse.
- R13: `nmi_done` on a core with no NMI in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 = extended (32-bit) destination mode, 0 = compatible (8-bit) mode |
| cmd_src | input | SRC_W | Index of the core issuing the command |
| cmd_hi_we | input | 1 | Write strobe for the destination (high) half |
| cmd_lo_we | input | 1 | Write strobe for the low half; triggers the send |
| cmd_wdata | input | 32 | Write data for either half |
| nmi_done | input | NCORES | Per-core end-of-NMI-handler pulse |
| fix_vld | output | NCORES | Per-core fixed-interrupt request pulse |
| fix_vec | output | NCORES*8 | Per-core fixed-interrupt vector, core i in bits [8i+7:8i] |
| nmi_fire | output | NCORES | Per-core NMI entry pulse |

## Verification
Every result is due one clock edge after its cause:
- `fix_vld`, `fix_vec` and an arrival's `nmi_fire` follow the edge that samples the low write.
- A pending NMI's `nmi_fire` follows the edge that samples `nmi_done`.

The bench drives inputs at the falling edge and samples at the next falling edge, which is exactly one rising edge later. To show that each pulse lasts a single cycle and that merged or ignored events produce nothing, the bench looks once more at the following falling edge. For ordering, the bench issues the NMI and the fixed command on consecutive edges. It then checks that the NMI pulse appears at the first sample and the fixed pulse only at the second.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int VEC_W  = 8;
  localparam int CMD_W  = 32;

  // low-word field positions (decoded by the dispatcher)
  localparam int VEC_LSB = 0;
  localparam int DM_LSB  = 8;
  localparam int DM_W    = 3;
  localparam int SH_LSB  = 18;
  localparam int SH_W    = 2;

  typedef enum logic [SH_W-1:0] {
    SH_DEST   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [DM_W-1:0] DM_FIXED = 3'b000;
  localparam logic [DM_W-1:0] DM_NMI   = 3'b100;

  localparam logic [7:0]       COMPAT_BCAST = 8'hFF;
  localparam logic [CMD_W-1:0] EXT_BCAST    = 32'hFFFF_FFFF;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int SRC_W  = 2
) (
  input  logic                ext_mode,
  input  logic [CMD_W-1:0]    dest,
  input  logic [CMD_W-1:0]    cmd,
  input  logic [SRC_W-1:0]    src,
  output logic [NCORES-1:0]   tgt,
  output logic                is_fix,
  output logic                is_nmi,
  output logic [VEC_W-1:0]    vec
);

  logic [DM_W-1:0]   dmode;
  shorthand_e        sh;
  logic              bcast;
  logic [NCORES-1:0] self_m;
  logic [NCORES-1:0] phys_m;

  assign dmode  = cmd[DM_LSB +: DM_W];
  assign sh     = shorthand_e'(cmd[SH_LSB +: SH_W]);
  assign vec    = cmd[VEC_LSB +: VEC_W];
  assign is_fix = (dmode == DM_FIXED);
  assign is_nmi = (dmode == DM_NMI);
  assign bcast  = ext_mode ? (dest == EXT_BCAST) : (dest[7:0] == COMPAT_BCAST);

  always_comb begin
    for (int i = 0; i < NCORES; i++) begin
      self_m[i] = (src == SRC_W'(i));
      phys_m[i] = ext_mode ? (dest == CMD_W'(i)) : (dest[7:0] == 8'(i));
    end
  end

  always_comb begin
    unique case (sh)
      SH_DEST:   tgt = bcast ? {NCORES{1'b1}} : phys_m;
      SH_SELF:   tgt = self_m;
      SH_ALL:    tgt = {NCORES{1'b1}};
      SH_OTHERS: tgt = ~self_m;
      default:   tgt = '0;
    endcase
  end

endmodule

// File: rtl/ipi_nmi_slot.sv
module ipi_nmi_slot (
  input  logic clk,
  input  logic rst,
  input  logic arrive,
  input  logic done,
  output logic fire
);

  logic svc_q;
  logic pend_q;
  logic fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q  <= 1'b0;
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (done && svc_q) begin
        if (pend_q) begin
          fire_q <= 1'b1;
          pend_q <= arrive;
        end else if (arrive) begin
          fire_q <= 1'b1;
        end else begin
          svc_q <= 1'b0;
        end
      end else if (arrive) begin
        if (!svc_q) begin
          svc_q  <= 1'b1;
          fire_q <= 1'b1;
        end else begin
          pend_q <= 1'b1;  // already pending: merged
        end
      end
    end
  end

  assign fire = fire_q;

  a_r9_pend_needs_svc: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> svc_q);

  a_r8_fire_has_cause: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> ($past(arrive) || $past(done && pend_q)));

  a_r13_idle_done_inert: assert property (@(posedge clk) disable iff (rst)
    (!svc_q && !arrive) |=> (!svc_q && !fire_q));

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int SRC_W  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ext_mode,
  input  logic [SRC_W-1:0]          cmd_src,
  input  logic                      cmd_hi_we,
  input  logic                      cmd_lo_we,
  input  logic [CMD_W-1:0]          cmd_wdata,
  input  logic [NCORES-1:0]         nmi_done,
  output logic [NCORES-1:0]         fix_vld,
  output logic [NCORES*VEC_W-1:0]   fix_vec,
  output logic [NCORES-1:0]         nmi_fire
);

  logic [CMD_W-1:0]  dest_q;
  logic [NCORES-1:0] tgt;
  logic              is_fix;
  logic              is_nmi;
  logic [VEC_W-1:0]  vec;

  always_ff @(posedge clk) begin
    if (rst) dest_q <= '0;
    else if (cmd_hi_we) dest_q <= cmd_wdata;
  end

  ipi_cmd_decode #(.NCORES(NCORES), .SRC_W(SRC_W)) dec_i (
    .ext_mode (ext_mode),
    .dest     (dest_q),
    .cmd      (cmd_wdata),
    .src      (cmd_src),
    .tgt      (tgt),
    .is_fix   (is_fix),
    .is_nmi   (is_nmi),
    .vec      (vec)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    logic             vld_q;
    logic [VEC_W-1:0] vec_q;
    logic             send_fix;

    assign send_fix = cmd_lo_we && is_fix && tgt[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        vec_q <= '0;
      end else begin
        vld_q <= send_fix;
        if (send_fix) vec_q <= vec;
      end
    end

    assign fix_vld[g]                 = vld_q;
    assign fix_vec[g*VEC_W +: VEC_W]  = vec_q;

    ipi_nmi_slot slot_i (
      .clk    (clk),
      .rst    (rst),
      .arrive (cmd_lo_we && is_nmi && tgt[g]),
      .done   (nmi_done[g]),
      .fire   (nmi_fire[g])
    );
  end

  a_r2_fix_needs_write: assert property (@(posedge clk) disable iff (rst)
    (|fix_vld) |-> $past(cmd_lo_we));

  a_r2_hi_write_sends_nothing: assert property (@(posedge clk) disable iff (rst)
    (cmd_hi_we && !cmd_lo_we) |=> (fix_vld == '0));

endmodule

// File: tb/ipi_dispatch_tb_top.sv
module ipi_dispatch_tb_top;

  localparam int N  = 4;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ext_mode = 1'b0;
  logic [SW-1:0]   cmd_src = '0;
  logic            cmd_hi_we = 1'b0;
  logic            cmd_lo_we = 1'b0;
  logic [31:0]     cmd_wdata = '0;
  logic [N-1:0]    nmi_done = '0;
  logic [N-1:0]    fix_vld;
  logic [N*8-1:0]  fix_vec;
  logic [N-1:0]    nmi_fire;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  ipi_dispatch #(.NCORES(N), .SRC_W(SW)) dut_i (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .cmd_src(cmd_src),
    .cmd_hi_we(cmd_hi_we), .cmd_lo_we(cmd_lo_we), .cmd_wdata(cmd_wdata),
    .nmi_done(nmi_done), .fix_vld(fix_vld), .fix_vec(fix_vec), .nmi_fire(nmi_fire)
  );

  // layout: [82] ext, [81:80] src, [79:48] hi, [47:16] lo, [15:12] fix mask, [11:4] vec, [3:0] nmi mask
  localparam int NV = 13;
  localparam logic [82:0] VTAB [NV] = '{
    {1'b0, 2'd0, 32'h0000_0002, 32'h0000_0031, 4'b0100, 8'h31, 4'b0000},
    {1'b0, 2'd0, 32'h0000_00FF, 32'h0000_00CF, 4'b1111, 8'hCF, 4'b0000},
    {1'b0, 2'd1, 32'h5A00_0103, 32'h0000_0012, 4'b1000, 8'h12, 4'b0000},
    {1'b1, 2'd1, 32'h5A00_0103, 32'h0000_0013, 4'b0000, 8'h00, 4'b0000},
    {1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_00A5, 4'b1111, 8'hA5, 4'b0000},
    {1'b1, 2'd0, 32'h0000_00FF, 32'h0000_00A6, 4'b0000, 8'h00, 4'b0000},
    {1'b1, 2'd2, 32'h0000_0002, 32'h0000_0021, 4'b0100, 8'h21, 4'b0000},
    {1'b0, 2'd1, 32'h0000_0003, 32'h0004_00F1, 4'b0010, 8'hF1, 4'b0000},
    {1'b0, 2'd2, 32'h0000_0000, 32'h0008_00CF, 4'b1111, 8'hCF, 4'b0000},
    {1'b0, 2'd2, 32'h0000_0000, 32'h000C_0066, 4'b1011, 8'h66, 4'b0000},
    {1'b0, 2'd0, 32'h0000_0001, 32'h0000_0455, 4'b0000, 8'h00, 4'b0010},
    {1'b0, 2'd3, 32'h0000_0002, 32'h0008_0455, 4'b0000, 8'h00, 4'b1111},
    {1'b0, 2'd0, 32'h0000_0002, 32'h0000_0277, 4'b0000, 8'h00, 4'b0000}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic write_hi(input logic [31:0] d);
    @(negedge clk);
    cmd_hi_we = 1'b1; cmd_wdata = d;
    @(negedge clk);
    cmd_hi_we = 1'b0;
  endtask

  // results of the low write are sampled at the negedge on return
  task automatic write_lo(input logic [SW-1:0] s, input logic [31:0] d);
    @(negedge clk);
    cmd_lo_we = 1'b1; cmd_src = s; cmd_wdata = d;
    @(negedge clk);
    cmd_lo_we = 1'b0;
  endtask

  task automatic pulse_done(input logic [N-1:0] m);
    @(negedge clk);
    nmi_done = m;
    @(negedge clk);
    nmi_done = '0;
  endtask

  task automatic clear_nmis();
    pulse_done('1);
    pulse_done('1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset fix_vld", 32'(fix_vld), 32'h0);
    check("R1 reset nmi_fire", 32'(nmi_fire), 32'h0);
    check("R1 reset fix_vec", fix_vec, 32'h0);

    // table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      logic [82:0] e;
      e = VTAB[k];
      ext_mode = e[82];
      write_hi(e[79:48]);
      check($sformatf("R2 hi write alone, entry %0d", k), 32'(fix_vld), 32'h0);
      write_lo(e[81:80], e[47:16]);
      check($sformatf("R3 R4 R5 R6 fix_vld entry %0d", k), 32'(fix_vld), 32'(e[15:12]));
      check($sformatf("R5 R6 nmi_fire entry %0d", k), 32'(nmi_fire), 32'(e[3:0]));
      for (int c = 0; c < N; c++)
        if (e[12+c])
          check($sformatf("R6 fix_vec core %0d entry %0d", c, k), 32'(fix_vec[c*8 +: 8]), 32'(e[11:4]));
      @(negedge clk);
      check($sformatf("R2 single-cycle pulse entry %0d", k), 32'(fix_vld), 32'h0);
      clear_nmis();
    end
    ext_mode = 1'b0;

    // R7: NMI vector ignored, fix_vec untouched
    write_hi(32'h1);
    write_lo(2'd0, 32'h0000_0031);
    write_lo(2'd0, 32'h0000_0455);
    check("R7 nmi raises no fix_vld", 32'(fix_vld), 32'h0);
    check("R7 nmi fires core1", 32'(nmi_fire), 32'h2);
    check("R7 fix_vec unchanged", 32'(fix_vec[15:8]), 32'h31);
    clear_nmis();

    // R8 R9 R10 on core 0 from different senders
    write_hi(32'h0);
    write_lo(2'd1, 32'h0000_0400);
    check("R8 first nmi fires", 32'(nmi_fire), 32'h1);
    write_lo(2'd2, 32'h0000_0400);
    check("R9 second nmi pends", 32'(nmi_fire), 32'h0);
    write_lo(2'd3, 32'h0000_0400);
    check("R10 third nmi no pulse", 32'(nmi_fire), 32'h0);
    pulse_done(4'b0001);
    check("R9 pending fires after done", 32'(nmi_fire), 32'h1);
    @(negedge clk);
    check("R9 pending pulse single", 32'(nmi_fire), 32'h0);
    pulse_done(4'b0001);
    check("R10 merged nmi not fired", 32'(nmi_fire), 32'h0);
    // R13: done on idle core
    pulse_done(4'b0001);
    check("R13 idle done no pulse", 32'(nmi_fire), 32'h0);
    write_lo(2'd1, 32'h0000_0400);
    check("R13 core still idle, nmi fires", 32'(nmi_fire), 32'h1);

    // R11: in service + pending, then done and arrival together
    write_lo(2'd1, 32'h0000_0400);
    check("R11 pend set", 32'(nmi_fire), 32'h0);
    @(negedge clk);
    nmi_done = 4'b0001; cmd_lo_we = 1'b1; cmd_src = 2'd2; cmd_wdata = 32'h0000_0400;
    @(negedge clk);
    nmi_done = '0; cmd_lo_we = 1'b0;
    check("R11 pending fires with concurrent arrival", 32'(nmi_fire), 32'h1);
    pulse_done(4'b0001);
    check("R11 new arrival was kept pending", 32'(nmi_fire), 32'h1);
    pulse_done(4'b0001);
    check("R11 idle afterwards", 32'(nmi_fire), 32'h0);

    // R12: NMI then fixed from the same sender
    write_hi(32'h1);
    @(negedge clk);
    cmd_lo_we = 1'b1; cmd_src = 2'd3; cmd_wdata = 32'h0000_0400;
    @(negedge clk);
    cmd_wdata = 32'h0000_0044;
    check("R12 nmi pulse first", 32'(nmi_fire), 32'h2);
    check("R12 fixed not yet", 32'(fix_vld), 32'h0);
    @(negedge clk);
    cmd_lo_we = 1'b0;
    check("R12 fixed pulse after", 32'(fix_vld), 32'h2);
    check("R12 fixed vector", 32'(fix_vec[15:8]), 32'h44);
    check("R12 no second nmi pulse", 32'(nmi_fire), 32'h0);
    clear_nmis();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule